// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Posted Write Queue

This block sits between a processor's load/store port and a slow word-wide memory. It keeps a small direct-mapped array of single-word lines. Each line holds a valid flag, a tag and one data word. The low bits of the word address select the line, and the remaining bits are compared against the stored tag. A read that finds its word returns it in the same cycle. A read that does not find it holds the processor stalled while the word is fetched and placed in the line.

Every store is posted into a small first-in, first-out queue that drains to memory in the background. The processor therefore continues at once unless the queue is full. A store that finds its word in the array also refreshes the cached copy. A store that misses leaves the array untouched: it goes around the cache and no line is allocated. A read miss sends its memory read only after the queue has emptied, so it can never fetch a word that an older store has not yet reached.

The processor side uses a request/stall handshake. A request completes on the rising edge at which `cpu_req` is high and `cpu_stall` is low, and the processor holds the request unchanged while stalled. The memory side raises `mem_req` and keeps it steady until `mem_ack`, which may arrive after any number of cycles.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid and the write queue is empty: `mem_req` is low while no request is presented, and the first read of any address misses.
- R2: With 8 lines, line index = address bits [2:0] and tag = the address bits above them. The read sequence 22, 26, 22, 26, 16, 3, 16, 18 on an empty cache gives miss, miss, hit, hit, miss, miss, hit, miss. Address 18 replaces 26 in line 2, so a later read of 26 misses.
- R3: A read hit completes without stall, with the cached word on `cpu_rdata` in the same cycle.
- R4: A read miss raises `cpu_stall` in its first cycle. It issues its memory read (`mem_we`=0) only once every earlier store has been acknowledged by memory. It fills the line on `mem_ack` and completes in the following cycle, returning the memory word.
- R5: Every accepted store is written to memory (`mem_we`=1) exactly once, in acceptance order, and one queue entry is retired per `mem_ack`.
- R6: A store whose address hits updates the cached word, so a following read of that address hits and returns the new data.
- R7: A store whose address misses allocates no line and changes no line: the line at that index keeps its old content, and a later read of the store's address misses and returns the stored data from memory.
- R8: A store stalls only when the queue already holds 4 entries; with fewer entries it completes in its first cycle.
- R9: Once raised, `mem_req` with its `mem_we`, `mem_addr` and `mem_wdata` stays unchanged until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when a load completes |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the current access |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` on a read |

## Verification
The assertions watch, on every cycle, that the queue is never pushed while full or popped while empty. They also check that a memory request stays frozen until acknowledged, that a memory read only appears while a stalled load is waiting, and that a completed fill turns the held load into a hit on the next cycle. Only the bench scenarios can show the things that depend on history. These are the hit/miss pattern of the address sequence, eviction, the value returned after a store hit or a store miss, and the order in which stores reach memory. They also cover the fifth back-to-back store stalling behind a slow memory, and no load being served before older stores have landed.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
   // Direction of a memory-side access
   typedef enum logic {
      MEM_OP_RD = 1'b0,
      MEM_OP_WR = 1'b1
   } wtc_memop_e;
endpackage

// File: rtl/wtc_line_store.sv
`timescale 1ns/1ps
// Direct-mapped line array: one word per line, valid + tag per line.
module wtc_line_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              upd_en,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [DATA_W-1:0] upd_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   logic [LINES-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [DATA_W-1:0] dat_q [LINES];

   logic [IDX_W-1:0]  lk_idx, upd_idx;
   logic [TAG_W-1:0]  lk_tag, upd_tag;

   assign lk_idx  = lk_addr[IDX_W-1:0];
   assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];
   assign upd_idx = upd_addr[IDX_W-1:0];
   assign upd_tag = upd_addr[ADDR_W-1:IDX_W];

   assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_data = dat_q[lk_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (upd_en) begin
         vld_q[upd_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (upd_en) begin
         tag_q[upd_idx] <= upd_tag;
         dat_q[upd_idx] <= upd_data;
      end
   end
endmodule

// File: rtl/wtc_wqueue.sv
`timescale 1ns/1ps
// Posted write queue, first-in first-out.
module wtc_wqueue #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic              empty,
   output logic              full
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int ENT_W = ADDR_W + DATA_W;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push && !pop) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop && !push) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));

   generate
      if (DEPTH == 1) begin : g_single
         logic [ENT_W-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (push) ent_q <= {push_addr, push_data};
         end
         assign {head_addr, head_data} = ent_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         logic [ENT_W-1:0] ent_q [DEPTH];
         logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
            end else begin
               if (push)
                  wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
               if (pop)
                  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (push) ent_q[wr_ptr_q] <= {push_addr, push_data};
         end
         assign {head_addr, head_data} = ent_q[rd_ptr_q];
      end
   endgenerate

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/wtc_mem_port.sv
`timescale 1ns/1ps
// Memory-side sequencer: queued stores first, a pending fill only once drained.
module wtc_mem_port
   import wtc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [ADDR_W-1:0] q_addr,
   input  logic [DATA_W-1:0] q_data,
   input  logic              fill_need,
   input  logic [ADDR_W-1:0] fill_addr,
   output logic              q_pop,
   output logic              fill_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack
);
   logic drain;
   wtc_memop_e op;

   assign drain     = !q_empty;
   assign op        = drain ? MEM_OP_WR : MEM_OP_RD;
   assign mem_req   = drain || fill_need;
   assign mem_we    = (op == MEM_OP_WR);
   assign mem_addr  = drain ? q_addr : fill_addr;
   assign mem_wdata = q_data;
   assign q_pop     = drain && mem_ack;
   assign fill_done = !drain && fill_need && mem_ack;

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && (!mem_we || $stable(mem_wdata))));
endmodule

// File: rtl/wtc_cache.sv
`timescale 1ns/1ps
// Direct-mapped, write-through, write-around cache with posted write queue.
module wtc_cache #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int LINES    = 8,
   parameter int Q_DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(LINES);

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the index width");
      end
      if (Q_DEPTH < 1) begin : g_bad_depth
         $error("Q_DEPTH must be at least 1");
      end
   endgenerate

   logic              lk_hit;
   logic [DATA_W-1:0] lk_data;
   logic              q_empty, q_full, q_pop;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_data;
   logic              rd_miss, wr_take, fill_done, upd_en;
   logic [DATA_W-1:0] upd_data;

   assign rd_miss   = cpu_req && !cpu_we && !lk_hit;
   assign wr_take   = cpu_req && cpu_we && !q_full;
   assign cpu_stall = rd_miss || (cpu_req && cpu_we && q_full);
   assign cpu_rdata = lk_data;
   assign upd_en    = fill_done || (wr_take && lk_hit);
   assign upd_data  = fill_done ? mem_rdata : cpu_wdata;

   wtc_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) lines_i (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(cpu_addr), .lk_hit(lk_hit), .lk_data(lk_data),
      .upd_en(upd_en), .upd_addr(cpu_addr), .upd_data(upd_data)
   );

   wtc_wqueue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(Q_DEPTH)) wq_i (
      .clk(clk), .rst_n(rst_n),
      .push(wr_take), .push_addr(cpu_addr), .push_data(cpu_wdata),
      .pop(q_pop), .head_addr(q_addr), .head_data(q_data),
      .empty(q_empty), .full(q_full)
   );

   wtc_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mp_i (
      .clk(clk), .rst_n(rst_n),
      .q_empty(q_empty), .q_addr(q_addr), .q_data(q_data),
      .fill_need(rd_miss), .fill_addr(cpu_addr),
      .q_pop(q_pop), .fill_done(fill_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack)
   );

   // R4
   fill_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (cpu_req && !cpu_we && cpu_stall));
   // R4
   fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (!cpu_req || !cpu_stall));
endmodule

// File: tb/wtc_cache_tb.sv
`timescale 1ns/1ps
module wtc_cache_tb_top;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic              cpu_stall;
   logic              mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_ack = 1'b0;
   logic [DATA_W-1:0] mem_rdata = '0;

   always #5 clk = ~clk;

   wtc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(8), .Q_DEPTH(4)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int errors = 0;
   int checks = 0;

   function automatic logic [31:0] init_word(input logic [7:0] a);
      return {24'hC0DE00, 8'h00} ^ {24'h0, a};
   endfunction

   // ---------------- memory model ----------------
   logic [31:0] mem [256];
   logic [7:0]  log_addr [64];
   int log_n = 0, wr_done = 0, rd_done = 0, pushed = 0, stale_rd = 0;
   int lat_base = 3, lat_cnt = 3, lat_var = 0;

   initial for (int i = 0; i < 256; i++) mem[i] = init_word(8'(i));

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (rst_n && mem_req) begin
         if (lat_cnt == 0) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr] = mem_wdata;
               if (log_n < 64) log_addr[log_n] = mem_addr;
               log_n++;
               wr_done++;
            end else begin
               mem_rdata <= mem[mem_addr];
               if (wr_done != pushed) stale_rd++;
               rd_done++;
            end
            lat_var = (lat_var + 1) % 3;
            lat_cnt = lat_base + lat_var;
         end else begin
            lat_cnt--;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [7:0] a, input logic [31:0] wd,
                         output bit first_stall, output logic [31:0] rd);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      #1;
      first_stall = cpu_stall;
      while (cpu_stall) begin
         @(negedge clk); #1;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0;
      if (we) pushed++;
   endtask

   task automatic wait_drain();
      while (wr_done != pushed) @(negedge clk);
      @(negedge clk);
   endtask

   // {expected miss, address}: R2 sequence
   localparam logic [8:0] SEQ [8] = '{9'h116, 9'h11A, 9'h016, 9'h01A,
                                      9'h110, 9'h103, 9'h010, 9'h112};

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      bit st;
      logic [31:0] rd;
      int rd0, lb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: idle after reset
      chk(!mem_req, "R1 mem_req idle", 32'(mem_req), 0);
      chk(!cpu_stall, "R1 stall idle", 32'(cpu_stall), 0);

      // R2/R3/R4: table walk
      foreach (SEQ[k]) begin
         rd0 = rd_done;
         access(1'b0, SEQ[k][7:0], '0, st, rd);
         chk(st == SEQ[k][8], $sformatf("R2 seq %0d hit/miss", k), 32'(st), 32'(SEQ[k][8]));
         chk(rd == init_word(SEQ[k][7:0]), $sformatf("R3 R4 seq %0d data", k), rd, init_word(SEQ[k][7:0]));
         chk((rd_done - rd0) == (SEQ[k][8] ? 1 : 0), $sformatf("R4 seq %0d mem reads", k),
             32'(rd_done - rd0), 32'(SEQ[k][8]));
      end
      // R2: 26 was evicted by 18
      access(1'b0, 8'd26, '0, st, rd);
      chk(st == 1'b1, "R2 eviction of 26", 32'(st), 1);
      // R1: address never touched misses
      access(1'b0, 8'd1, '0, st, rd);
      chk(st == 1'b1, "R1 first read misses", 32'(st), 1);

      // R6: store hit, then read hit new value
      access(1'b1, 8'd22, 32'h0000_1111, st, rd);
      chk(!st, "R8 store no stall", 32'(st), 0);
      access(1'b0, 8'd22, '0, st, rd);
      chk(!st, "R6 read after store hit", 32'(st), 0);
      chk(rd == 32'h0000_1111, "R6 updated word", rd, 32'h0000_1111);
      // R4: read miss behind pending store waits for drain
      lat_base = 6;
      access(1'b1, 8'd3, 32'h0000_3333, st, rd);
      access(1'b0, 8'd5, '0, st, rd);
      chk(st, "R4 miss stalls", 32'(st), 1);
      chk(stale_rd == 0, "R4 read after drain", 32'(stale_rd), 0);
      chk(rd == init_word(8'd5), "R4 fill data", rd, init_word(8'd5));
      wait_drain();
      chk(mem[22] == 32'h0000_1111, "R5 store reached memory", mem[22], 32'h0000_1111);

      // R7: store miss goes around
      access(1'b1, 8'd40, 32'h0000_4040, st, rd);
      chk(!st, "R7 store miss no stall", 32'(st), 0);
      access(1'b0, 8'd16, '0, st, rd);
      chk(!st && rd == init_word(8'd16), "R7 line 0 unchanged", rd, init_word(8'd16));
      access(1'b0, 8'd40, '0, st, rd);
      chk(st, "R7 no allocation", 32'(st), 1);
      chk(rd == 32'h0000_4040, "R7 data from memory", rd, 32'h0000_4040);

      // R8/R5: full queue behind slow memory
      wait_drain();
      lat_base = 20;
      lb = log_n;
      for (int j = 0; j < 5; j++) begin
         access(1'b1, 8'(100 + j), 32'(32'hF000 + j), st, rd);
         chk(st == (j == 4), $sformatf("R8 store %0d stall", j), 32'(st), 32'(j == 4));
      end
      wait_drain();
      for (int j = 0; j < 5; j++) begin
         chk(log_addr[lb + j] == 8'(100 + j), $sformatf("R5 order %0d", j),
             32'(log_addr[lb + j]), 32'(100 + j));
         chk(mem[100 + j] == 32'(32'hF000 + j), $sformatf("R5 data %0d", j),
             mem[100 + j], 32'(32'hF000 + j));
      end
      chk(log_n == lb + 5, "R5 write count", 32'(log_n), 32'(lb + 5));
      finish_run();
   end
endmodule